// File: doc/BRIEF.md
# Move Instruction Decoder with Index Prefix

This block decodes the 16-bit single-word transfer instructions of a processor in which every operation is a move, either from a register or from an immediate value into a register. Each word has three parts. The top bit is a format flag. Seven destination bits sit below it, and an 8-bit source field fills the low byte. The block breaks the word into a destination module and index and into either an immediate byte or a source module and index. It presents the result one cycle after the instruction is strobed in.

The destination field is one bit narrower than the source field, so a plain instruction can write only the lowest eight registers of a module. To reach a higher register, an earlier instruction loads a small prefix register through a separate write path. The prefix supplies two extra high destination index bits and one extra high source index bit, which gives 5-bit indices on both sides. A loaded prefix is consumed by the next valid instruction and then returns to zero. Every prefixed access therefore costs one extra instruction cycle. The decoded fields stay unchanged between instructions, so downstream register-file logic can sample them at any time.

Top module: `mov_decode`

## Requirements
- R1: While rst_ni is low, and immediately after it is released, every output is zero and no prefix is pending.
- R2: On a clock edge where instr_valid_i is high, the decoder captures the word, and the result appears on the outputs after that edge. The format flag is instr_i[15], copied to is_reg_src_o. dst_mod_o is instr_i[11:8], and dst_idx_o[2:0] is instr_i[14:12].
- R3: With the format flag at 0, imm_o equals instr_i[7:0], and src_mod_o and src_idx_o are zero.
- R4: With the format flag at 1, src_mod_o equals instr_i[3:0], src_idx_o[3:0] equals instr_i[7:4], and imm_o is zero.
- R5: If no prefix is pending when an instruction is decoded, dst_idx_o[4:3] and src_idx_o[4] are zero and pfx_used_o is low.
- R6: A clock edge with pfx_we_i high loads a pending prefix. For the next decoded instruction, pfx_data_i[1:0] becomes dst_idx_o[4:3], pfx_data_i[2] becomes src_idx_o[4] (register source only), and pfx_used_o is high. This holds even when the loaded value is zero.
- R7: A pending prefix applies to exactly one valid instruction. The instruction after it decodes without a prefix unless a new prefix was written in between.
- R8: A pending prefix survives any number of cycles without a valid instruction.
- R9: While instr_valid_i is low, dec_valid_o is low and all decoded field outputs keep their last values, whatever instr_i carries.
- R10: If a prefix write and a valid instruction share an edge, the instruction uses the prefix state from before that edge, and the newly written value applies to the following instruction. A second prefix write before any instruction replaces the first.
- R11: dec_valid_o is high for exactly one cycle after each edge on which instr_valid_i was high, so back-to-back instructions give back-to-back valid cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 16 | Instruction word |
| pfx_we_i | input | 1 | Load the prefix register |
| pfx_data_i | input | 3 | Prefix value: bit 2 source high bit, bits 1:0 destination high bits |
| dec_valid_o | output | 1 | Decoded fields updated by the previous edge |
| is_reg_src_o | output | 1 | Source is a register (format flag) |
| imm_o | output | 8 | Immediate source value |
| src_mod_o | output | 4 | Source module |
| src_idx_o | output | 5 | Source register index, prefix bit on top |
| dst_mod_o | output | 4 | Destination module |
| dst_idx_o | output | 5 | Destination register index, prefix bits on top |
| pfx_used_o | output | 1 | Decoded instruction consumed a prefix |

## Verification
The only hidden state is the pending-prefix flag and its three bits. If that state is wrong, it shows up at the ports on the first valid instruction after the corruption, as wrong high index bits or a wrong pfx_used_o. If the prefix is not cleared, the fault appears one instruction later, as a prefix carried onto an unprefixed word. An error in the output hold register shows up within one cycle, either as fields that follow instr_i while the strobe is low or as a dec_valid_o pulse that is late or missing.

// File: rtl/mov_decode_pkg.sv
package mov_decode_pkg;

  localparam int unsigned INSTR_W    = 16;
  localparam int unsigned FMT_BIT    = INSTR_W - 1;
  localparam int unsigned SRC_W      = 8;
  localparam int unsigned MOD_W      = 4;
  localparam int unsigned DST_W      = INSTR_W - 1 - SRC_W;
  localparam int unsigned SRC_BASE_W = SRC_W - MOD_W;
  localparam int unsigned DST_BASE_W = DST_W - MOD_W;
  localparam int unsigned PFX_DST_W  = 2;
  localparam int unsigned PFX_SRC_W  = 1;
  localparam int unsigned PFX_W      = PFX_DST_W + PFX_SRC_W;
  localparam int unsigned SRC_IDX_W  = SRC_BASE_W + PFX_SRC_W;
  localparam int unsigned DST_IDX_W  = DST_BASE_W + PFX_DST_W;

  // source extension in the MSB, destination extension below it
  typedef struct packed {
    logic [PFX_SRC_W-1:0] src_hi;
    logic [PFX_DST_W-1:0] dst_hi;
  } pfx_t;

  typedef struct packed {
    logic                 is_reg;
    logic [SRC_W-1:0]     imm;
    logic [MOD_W-1:0]     src_mod;
    logic [SRC_IDX_W-1:0] src_idx;
    logic [MOD_W-1:0]     dst_mod;
    logic [DST_IDX_W-1:0] dst_idx;
    logic                 pfx_used;
  } dec_t;

endpackage

// File: rtl/mov_prefix_reg.sv
module mov_prefix_reg
  import mov_decode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  pfx_t data_i,
  input  logic consume_i,
  output pfx_t pfx_o,
  output logic pending_o
);

  pfx_t pfx_q;
  logic pend_q;

  // a write wins over consumption so a same-edge write arms the next word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pfx_q  <= '0;
      pend_q <= 1'b0;
    end else if (we_i) begin
      pfx_q  <= data_i;
      pend_q <= 1'b1;
    end else if (consume_i) begin
      pfx_q  <= '0;
      pend_q <= 1'b0;
    end
  end

  assign pfx_o     = pfx_q;
  assign pending_o = pend_q;

endmodule

// File: rtl/mov_field_split.sv
module mov_field_split
  import mov_decode_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  pfx_t               pfx_i,
  input  logic               pfx_pending_i,
  output dec_t               dec_o
);

  logic [SRC_W-1:0] src_field;
  logic [DST_W-1:0] dst_field;

  assign src_field = instr_i[SRC_W-1:0];
  assign dst_field = instr_i[SRC_W +: DST_W];

  always_comb begin
    dec_o          = '0;
    dec_o.is_reg   = instr_i[FMT_BIT];
    dec_o.dst_mod  = dst_field[MOD_W-1:0];
    dec_o.dst_idx  = {pfx_i.dst_hi, dst_field[MOD_W +: DST_BASE_W]};
    dec_o.pfx_used = pfx_pending_i;
    if (instr_i[FMT_BIT]) begin
      dec_o.src_mod = src_field[MOD_W-1:0];
      dec_o.src_idx = {pfx_i.src_hi, src_field[MOD_W +: SRC_BASE_W]};
    end else begin
      dec_o.imm = src_field;
    end
  end

endmodule

// File: rtl/mov_decode_hold.sv
module mov_decode_hold
  import mov_decode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  dec_t dec_i,
  output logic vld_o,
  output dec_t dec_o
);

  dec_t dec_q;
  logic vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= load_i;
      if (load_i) dec_q <= dec_i;
    end
  end

  assign vld_o = vld_q;
  assign dec_o = dec_q;

endmodule

// File: rtl/mov_decode.sv
module mov_decode
  import mov_decode_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 instr_valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic                 pfx_we_i,
  input  logic [PFX_W-1:0]     pfx_data_i,
  output logic                 dec_valid_o,
  output logic                 is_reg_src_o,
  output logic [SRC_W-1:0]     imm_o,
  output logic [MOD_W-1:0]     src_mod_o,
  output logic [SRC_IDX_W-1:0] src_idx_o,
  output logic [MOD_W-1:0]     dst_mod_o,
  output logic [DST_IDX_W-1:0] dst_idx_o,
  output logic                 pfx_used_o
);

  pfx_t pfx_cur;
  logic pfx_pend;
  dec_t dec_comb;
  dec_t dec_q;

  mov_prefix_reg i_pfx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (pfx_we_i),
    .data_i    (pfx_t'(pfx_data_i)),
    .consume_i (instr_valid_i),
    .pfx_o     (pfx_cur),
    .pending_o (pfx_pend)
  );

  mov_field_split i_split (
    .instr_i       (instr_i),
    .pfx_i         (pfx_cur),
    .pfx_pending_i (pfx_pend),
    .dec_o         (dec_comb)
  );

  mov_decode_hold i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (instr_valid_i),
    .dec_i  (dec_comb),
    .vld_o  (dec_valid_o),
    .dec_o  (dec_q)
  );

  assign is_reg_src_o = dec_q.is_reg;
  assign imm_o        = dec_q.imm;
  assign src_mod_o    = dec_q.src_mod;
  assign src_idx_o    = dec_q.src_idx;
  assign dst_mod_o    = dec_q.dst_mod;
  assign dst_idx_o    = dec_q.dst_idx;
  assign pfx_used_o   = dec_q.pfx_used;

endmodule

// File: rtl/mov_decode_chk.sv
module mov_decode_chk
  import mov_decode_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 instr_valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic                 pfx_we_i,
  input  logic [PFX_W-1:0]     pfx_data_i,
  input  logic                 dec_valid_o,
  input  logic                 is_reg_src_o,
  input  logic [SRC_W-1:0]     imm_o,
  input  logic [MOD_W-1:0]     src_mod_o,
  input  logic [SRC_IDX_W-1:0] src_idx_o,
  input  logic [MOD_W-1:0]     dst_mod_o,
  input  logic [DST_IDX_W-1:0] dst_idx_o,
  input  logic                 pfx_used_o
);

  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (!dec_valid_o && !pfx_used_o && dst_idx_o == '0 && imm_o == '0)
        else $error("outputs not cleared in reset");
    end
  end

  assert_vld_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> dec_valid_o == $past(instr_valid_i));

  assert_hold_fields_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(instr_valid_i) |->
      $stable({is_reg_src_o, imm_o, src_mod_o, src_idx_o, dst_mod_o, dst_idx_o, pfx_used_o}));

  assert_dst_mod_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(instr_valid_i) |->
      dst_mod_o == $past(instr_i[SRC_W +: MOD_W]) && is_reg_src_o == $past(instr_i[FMT_BIT]));

  assert_imm_src_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_reg_src_o |-> src_mod_o == '0 && src_idx_o == '0);

  assert_reg_imm_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_reg_src_o |-> imm_o == '0);

  assert_no_pfx_hi_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pfx_used_o |-> dst_idx_o[DST_IDX_W-1:DST_BASE_W] == '0 && src_idx_o[SRC_IDX_W-1:SRC_BASE_W] == '0);

endmodule

bind mov_decode mov_decode_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .instr_i       (instr_i),
  .pfx_we_i      (pfx_we_i),
  .pfx_data_i    (pfx_data_i),
  .dec_valid_o   (dec_valid_o),
  .is_reg_src_o  (is_reg_src_o),
  .imm_o         (imm_o),
  .src_mod_o     (src_mod_o),
  .src_idx_o     (src_idx_o),
  .dst_mod_o     (dst_mod_o),
  .dst_idx_o     (dst_idx_o),
  .pfx_used_o    (pfx_used_o)
);

// File: tb/test_mov_decode.sv
`timescale 1ns/1ps
module test_mov_decode;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic        pfx_we_i = 1'b0;
  logic [2:0]  pfx_data_i = '0;
  logic        dec_valid_o, is_reg_src_o, pfx_used_o;
  logic [7:0]  imm_o;
  logic [3:0]  src_mod_o, dst_mod_o;
  logic [4:0]  src_idx_o, dst_idx_o;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  mov_decode i_mov_decode (.*);

  // {pfx_we, pfx_data[2:0], instr[15:0], is_reg, imm[7:0], smod[3:0], sidx[4:0], dmod[3:0], didx[4:0], used}
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {1'b0, 3'b000, 16'h3A5C, 1'b0, 8'h5C, 4'h0, 5'h00, 4'hA, 5'h03, 1'b0},
    {1'b0, 3'b000, 16'hF7B2, 1'b1, 8'h00, 4'h2, 5'h0B, 4'h7, 5'h07, 1'b0},
    {1'b1, 3'b111, 16'h8123, 1'b1, 8'h00, 4'h3, 5'h12, 4'h1, 5'h18, 1'b1},
    {1'b1, 3'b010, 16'h45FF, 1'b0, 8'hFF, 4'h0, 5'h00, 4'h5, 5'h14, 1'b1},
    {1'b1, 3'b100, 16'hFFFF, 1'b1, 8'h00, 4'hF, 5'h1F, 4'hF, 5'h07, 1'b1},
    {1'b1, 3'b001, 16'h7F00, 1'b0, 8'h00, 4'h0, 5'h00, 4'hF, 5'h0F, 1'b1},
    {1'b0, 3'b000, 16'h8000, 1'b1, 8'h00, 4'h0, 5'h00, 4'h0, 5'h00, 1'b0},
    {1'b1, 3'b000, 16'h0C81, 1'b0, 8'h81, 4'h0, 5'h00, 4'hC, 5'h00, 1'b1}
  };

  localparam logic [27:0] F_A  = {1'b0, 8'h5C, 4'h0, 5'h00, 4'hA, 5'h03, 1'b0};
  localparam logic [27:0] F_B  = {1'b1, 8'h00, 4'h2, 5'h0B, 4'h7, 5'h07, 1'b0};
  localparam logic [27:0] F_81 = {1'b0, 8'h81, 4'h0, 5'h00, 4'hC, 5'h00, 1'b1};

  function automatic logic [27:0] reg0(logic [4:0] sidx, logic [4:0] didx, logic used);
    return {1'b1, 8'h00, 4'h0, sidx, 4'h0, didx, used};
  endfunction

  task automatic check(string tag, logic exp_v, logic [27:0] exp_f);
    logic [27:0] act;
    act = {is_reg_src_o, imm_o, src_mod_o, src_idx_o, dst_mod_o, dst_idx_o, pfx_used_o};
    n_vec++;
    if (act !== exp_f || dec_valid_o !== exp_v) begin
      n_err++;
      $display("FAIL %s: actual v=%b f=%h expected v=%b f=%h", tag, dec_valid_o, act, exp_v, exp_f);
    end
  endtask

  task automatic write_pfx(logic [2:0] d);
    pfx_we_i = 1'b1; pfx_data_i = d;
    @(negedge clk_i);
    pfx_we_i = 1'b0;
  endtask

  task automatic issue(logic [15:0] w);
    instr_i = w; instr_valid_i = 1'b1;
    @(negedge clk_i);
    instr_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_vec++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 in reset", 1'b0, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", 1'b0, '0);

    // table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][47]) write_pfx(VEC[i][46:44]);
      issue(VEC[i][43:28]);
      check($sformatf("R2/R3/R4/R5/R6/R7 vector %0d", i), 1'b1, VEC[i][27:0]);
    end

    // R9: fields hold while strobe low, instr_i changing
    instr_i = 16'hFFFF;
    @(negedge clk_i);
    instr_i = 16'h1234;
    @(negedge clk_i);
    check("R9 hold", 1'b0, F_81);

    // R8: prefix persists across idle cycles, R7: then cleared
    write_pfx(3'b011);
    repeat (3) @(negedge clk_i);
    issue(16'h8000);
    check("R8 prefix kept over idle", 1'b1, reg0(5'h00, 5'h18, 1'b1));
    issue(16'h8000);
    check("R7 prefix one-shot", 1'b1, reg0(5'h00, 5'h00, 1'b0));

    // R10: same-edge write and instruction
    pfx_we_i = 1'b1; pfx_data_i = 3'b110;
    instr_i = 16'h8000; instr_valid_i = 1'b1;
    @(negedge clk_i);
    pfx_we_i = 1'b0; instr_valid_i = 1'b0;
    check("R10 same edge uses old state", 1'b1, reg0(5'h00, 5'h00, 1'b0));
    issue(16'h8000);
    check("R10 same edge value applies next", 1'b1, reg0(5'h10, 5'h10, 1'b1));

    // R10: later write replaces earlier
    write_pfx(3'b111);
    write_pfx(3'b001);
    issue(16'h8000);
    check("R10 overwrite", 1'b1, reg0(5'h00, 5'h08, 1'b1));

    // R11: back-to-back instructions
    instr_i = 16'h3A5C; instr_valid_i = 1'b1;
    @(negedge clk_i);
    check("R11 first of pair", 1'b1, F_A);
    instr_i = 16'hF7B2;
    @(negedge clk_i);
    instr_valid_i = 1'b0;
    check("R11 second of pair", 1'b1, F_B);
    @(negedge clk_i);
    check("R11 valid drops", 1'b0, F_B);

    // R1: reset mid-run drops a pending prefix
    write_pfx(3'b111);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 mid-run reset", 1'b0, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    issue(16'h8000);
    check("R1 prefix cleared by reset", 1'b1, reg0(5'h00, 5'h00, 1'b0));

    finish_run();
  end

endmodule